// File: doc/BRIEF.md
# Multi-Channel Hit Merger

This block collects time measurements from eight detector channels and funnels them into one shared latency buffer. Each channel owns a four-entry queue that absorbs bursts of hits. A round-robin arbiter pulls from the queues at a rate of at most one hit per system clock and writes each hit as a single word holding the measurement and the number of the channel it came from. Hit strobes are expected to be synchronous to the system clock, one cycle wide per hit.

A hit that arrives at a channel whose queue is already full is thrown away, and a sticky per-channel flag records the loss until a status read clears it. The block counts how many words sit in the latency buffer: each write raises the count and each read strobe from the consumer lowers it. If a hit wins arbitration while the buffer is full, that hit is discarded, and the next word that does reach the buffer carries a lost-data marker, so downstream logic can tag the affected event.

Top module: `hit_merger`

## Requirements
- R1: Each channel queue holds up to 4 measurements and hands them out in arrival order. A hit strobe on a channel whose queue already holds 4 entries is discarded and sets that channel's bit in `drop_flags`.
- R2: The full-queue test uses the count held before the clock edge. A hit that reaches a full queue in the same cycle as that queue is being drained is still discarded.
- R3: The write port asserts `lb_wr_en` for at most one word per cycle. The word holds the lost marker in bit 19, the channel number in bits 18:16 and the measurement in bits 15:0.
- R4: Arbitration is round robin. After a grant to channel c, the next grant goes to the first non-empty queue in the order c+1, c+2, and so on, wrapping after 7. After reset the search starts at channel 0.
- R5: A hit on an idle block with an empty queue is strobed at clock edge k. The hit appears on the write port in the cycle after edge k+1.
- R6: `lb_occ` rises by one for each write and falls by one for each `lb_rd_en` while it is non-zero. A write and a read in the same cycle leave it unchanged. A read while it is zero is ignored. It never exceeds 256.
- R7: `lb_full` is high exactly when `lb_occ` equals 256. A hit granted while the buffer is full is dropped without a write, and `lb_occ` does not change. The next word actually written carries the lost marker (bit 19 = 1), and the words after it carry 0.
- R8: `drop_flags` bits stay set until `stat_rd` is pulsed, which clears them. A discard in the same cycle as `stat_rd` leaves its bit set.
- R9: Reset sets these values: no write, `lb_occ` = 0, `lb_full` = 0, and `drop_flags` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| hit_vld | input | 8 | Per-channel hit strobe |
| hit_meas | input | 128 | Per-channel 16-bit measurement, channel c at bits 16c+15:16c |
| lb_rd_en | input | 1 | Consumer removed one word from the latency buffer |
| stat_rd | input | 1 | Status read; clears the sticky drop flags |
| lb_wr_en | output | 1 | Write strobe into the latency buffer |
| lb_wr_data | output | 20 | {lost marker, channel, measurement} |
| lb_occ | output | 9 | Latency buffer occupancy |
| lb_full | output | 1 | Latency buffer holds 256 words |
| drop_flags | output | 8 | Sticky per-channel queue-overflow flags |

## Verification
Two functions can act on the same clock edge: a queue-overflow discard setting a drop flag, and a status read clearing the flags. The bench provokes this by flooding every channel so that the queues stay full, then pulsing `stat_rd` while the strobes continue. The rule is that the fresh discard wins and its bit stays set. A bench model predicts the flag vector every cycle. The same model predicts queue contents, arbitration order, occupancy and the lost marker across a fill-to-overflow phase followed by a drain phase.

// File: rtl/hm_pkg.sv
package hm_pkg;
  localparam int unsigned HM_NCH      = 8;
  localparam int unsigned HM_QDEPTH   = 4;
  localparam int unsigned HM_MEAS_W   = 16;
  localparam int unsigned HM_LB_DEPTH = 256;

  // next slot after base, stepping by step, modulo n
  function automatic int unsigned hm_rr_slot(input int unsigned base,
                                             input int unsigned step,
                                             input int unsigned n);
    return (base + step) % n;
  endfunction
endpackage

// File: rtl/hm_chan_queue.sv
// Per-channel derandomizer queue; DEPTH must be a power of two.
module hm_chan_queue #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         not_empty,
  output logic         dropped
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_nx;
  logic [AW-1:0] rd_ptr, rd_ptr_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic          is_full, acc, take, cnt_en;

  always_comb begin
    is_full   = (cnt == CW'(DEPTH));
    acc       = push && !is_full;
    take      = pop && (cnt != '0);
    wr_ptr_nx = acc  ? wr_ptr + AW'(1) : wr_ptr;
    rd_ptr_nx = take ? rd_ptr + AW'(1) : rd_ptr;
    cnt_nx    = cnt + CW'(acc) - CW'(take);
    cnt_en    = acc || take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (cnt_en) begin
      wr_ptr <= wr_ptr_nx;
      rd_ptr <= rd_ptr_nx;
      cnt    <= cnt_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) mem[wr_ptr] <= din;
  end

  assign dout      = mem[rd_ptr];
  assign not_empty = (cnt != '0);
  assign dropped   = push && is_full;
endmodule

// File: rtl/hm_rr_arb.sv
// Round-robin arbiter; search starts after the last granted requester.
module hm_rr_arb #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          gnt_vld,
  output logic [IW-1:0] gnt_idx
);
  import hm_pkg::*;

  logic [IW-1:0] last, last_nx;

  always_comb begin
    int unsigned c;
    gnt_vld = 1'b0;
    gnt_idx = '0;
    c       = 0;
    for (int unsigned k = 1; k <= N; k++) begin
      c = hm_rr_slot(int'(last), k, N);
      if (!gnt_vld && req[c]) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'(c);
      end
    end
    last_nx = gnt_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               last <= IW'(N - 1);
    else if (adv && gnt_vld)  last <= last_nx;
  end
endmodule

// File: rtl/hm_occ_tracker.sv
// Latency buffer occupancy counter.
module hm_occ_tracker #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned OW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [OW-1:0] occ,
  output logic          full
);
  logic          dec_ok, occ_en;
  logic [OW-1:0] occ_nx;

  always_comb begin
    dec_ok = dec && (occ != '0);
    occ_nx = occ + OW'(inc) - OW'(dec_ok);
    occ_en = inc ^ dec_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ <= '0;
    else if (occ_en) occ <= occ_nx;
  end

  assign full = (occ == OW'(DEPTH));
endmodule

// File: rtl/hit_merger.sv
module hit_merger
  import hm_pkg::*;
#(
  parameter int unsigned NCH      = HM_NCH,
  parameter int unsigned QDEPTH   = HM_QDEPTH,
  parameter int unsigned MEAS_W   = HM_MEAS_W,
  parameter int unsigned LB_DEPTH = HM_LB_DEPTH,
  localparam int unsigned IW      = $clog2(NCH),
  localparam int unsigned WW      = 1 + IW + MEAS_W,
  localparam int unsigned OW      = $clog2(LB_DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        hit_vld,
  input  logic [NCH*MEAS_W-1:0] hit_meas,
  input  logic                  lb_rd_en,
  input  logic                  stat_rd,
  output logic                  lb_wr_en,
  output logic [WW-1:0]         lb_wr_data,
  output logic [OW-1:0]         lb_occ,
  output logic                  lb_full,
  output logic [NCH-1:0]        drop_flags
);
  logic [MEAS_W-1:0] q_dout [NCH];
  logic [NCH-1:0]    q_nemp, q_pop, q_drop;
  logic              gnt_vld;
  logic [IW-1:0]     gnt_idx;
  logic              wr_ok;
  logic              lost_q, lost_nx, lost_en;
  logic              wr_en_nx;
  logic [WW-1:0]     wr_data_nx;
  logic [NCH-1:0]    flags_nx;
  logic              flags_en;

  // per-channel queues
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign q_pop[c] = gnt_vld && (gnt_idx == IW'(c));
    hm_chan_queue #(.DEPTH(QDEPTH), .W(MEAS_W)) u_q (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (hit_vld[c]),
      .din      (hit_meas[c*MEAS_W +: MEAS_W]),
      .pop      (q_pop[c]),
      .dout     (q_dout[c]),
      .not_empty(q_nemp[c]),
      .dropped  (q_drop[c])
    );
  end

  hm_rr_arb #(.N(NCH), .IW(IW)) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (q_nemp),
    .adv    (1'b1),
    .gnt_vld(gnt_vld),
    .gnt_idx(gnt_idx)
  );

  hm_occ_tracker #(.DEPTH(LB_DEPTH), .OW(OW)) u_occ (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (wr_ok),
    .dec  (lb_rd_en),
    .occ  (lb_occ),
    .full (lb_full)
  );

  // merge stage next state
  always_comb begin
    wr_ok      = gnt_vld && !lb_full;
    wr_en_nx   = wr_ok;
    wr_data_nx = {lost_q, gnt_idx, q_dout[gnt_idx]};
    lost_nx    = lost_q;
    if (gnt_vld && lb_full) lost_nx = 1'b1;
    else if (wr_ok)         lost_nx = 1'b0;
    lost_en    = gnt_vld;
    flags_nx   = (drop_flags & ~{NCH{stat_rd}}) | q_drop;
    flags_en   = stat_rd || (q_drop != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_wr_en   <= 1'b0;
      lost_q     <= 1'b0;
      drop_flags <= '0;
    end else begin
      lb_wr_en <= wr_en_nx;
      if (lost_en)  lost_q     <= lost_nx;
      if (flags_en) drop_flags <= flags_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) lb_wr_data <= wr_data_nx;
  end
endmodule

// File: rtl/hit_merger_chk.sv
module hit_merger_chk #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned OW    = 9,
  parameter int unsigned DEPTH = 256
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] hit_vld,
  input logic           lb_rd_en,
  input logic           stat_rd,
  input logic           lb_wr_en,
  input logic [OW-1:0]  lb_occ,
  input logic           lb_full,
  input logic [NCH-1:0] drop_flags
);
  localparam int unsigned XW = OW + 1;

  // R6: occupancy follows writes and accepted reads
  assert_occ_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, lb_occ} == {1'b0, $past(lb_occ)} + XW'(lb_wr_en)
              - XW'($past(lb_rd_en) && ($past(lb_occ) != '0))));

  // R6: never above capacity
  assert_occ_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, lb_occ} <= XW'(DEPTH));

  // R7: no write lands while full
  assert_no_write_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lb_full |=> !lb_wr_en);

  // R8: set bits hold without a status read
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd |=> ((drop_flags & $past(drop_flags)) == $past(drop_flags)));

  // R8: status read with no new hits empties the flags
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (hit_vld == '0)) |=> (drop_flags == '0));
endmodule

bind hit_merger hit_merger_chk #(.NCH(NCH), .OW(OW), .DEPTH(LB_DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hit_vld   (hit_vld),
  .lb_rd_en  (lb_rd_en),
  .stat_rd   (stat_rd),
  .lb_wr_en  (lb_wr_en),
  .lb_occ    (lb_occ),
  .lb_full   (lb_full),
  .drop_flags(drop_flags)
);

// File: tb/test_hit_merger.sv
`timescale 1ns/1ps
module test_hit_merger;
  logic         clk;
  logic         rst_n;
  logic [7:0]   hit_vld;
  logic [127:0] hit_meas;
  logic         lb_rd_en;
  logic         stat_rd;
  logic         lb_wr_en;
  logic [19:0]  lb_wr_data;
  logic [8:0]   lb_occ;
  logic         lb_full;
  logic [7:0]   drop_flags;

  int total = 0;
  int bad   = 0;
  int nflag = 0;
  int nfull = 0;

  // bench model state
  logic [15:0] mq [8][4];
  int          mcnt [8];
  int          mlast;
  int          mocc;
  bit          mlost;
  bit [7:0]    mflags;
  bit          mwe;
  logic [19:0] mwd;

  hit_merger i_hit_merger (
    .clk(clk), .rst_n(rst_n), .hit_vld(hit_vld), .hit_meas(hit_meas),
    .lb_rd_en(lb_rd_en), .stat_rd(stat_rd), .lb_wr_en(lb_wr_en),
    .lb_wr_data(lb_wr_data), .lb_occ(lb_occ), .lb_full(lb_full),
    .drop_flags(drop_flags)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int c = 0; c < 8; c++) mcnt[c] = 0;
    mlast = 7; mocc = 0; mlost = 0; mflags = '0; mwe = 0; mwd = '0;
  endtask

  // model of one clock edge, from the requirements
  task automatic model_edge();
    int  pre [8];
    int  w;
    bit  found;
    bit  wr_this;
    bit  rd_ok;
    bit [7:0] drops;
    found = 0; w = 0; wr_this = 0; drops = '0;
    for (int c = 0; c < 8; c++) pre[c] = mcnt[c];
    for (int k = 1; k <= 8; k++) begin
      int c;
      c = (mlast + k) % 8;
      if (!found && mcnt[c] > 0) begin found = 1; w = c; end
    end
    mwe = 0;
    if (found) begin
      logic [15:0] m;
      m = mq[w][0];
      for (int i = 0; i < 3; i++) mq[w][i] = mq[w][i+1];
      mcnt[w]--;
      if (mocc < 256) begin
        mwe = 1; wr_this = 1;
        mwd = {mlost, 3'(w), m};
        mlost = 0;
      end else begin
        mlost = 1;
      end
      mlast = w;
    end
    rd_ok = lb_rd_en && (mocc > 0);
    mocc = mocc + int'(wr_this) - int'(rd_ok);
    for (int c = 0; c < 8; c++) begin
      if (hit_vld[c]) begin
        if (pre[c] == 4) drops[c] = 1'b1;   // R2: pre-edge count decides
        else begin
          mq[c][mcnt[c]] = hit_meas[c*16 +: 16];
          mcnt[c]++;
        end
      end
    end
    mflags = (stat_rd ? 8'h00 : mflags) | drops;
  endtask

  task automatic cycle(input logic [7:0] hv, input bit rd, input bit sr);
    @(negedge clk);
    hit_vld  = hv;
    for (int c = 0; c < 8; c++) hit_meas[c*16 +: 16] = 16'($urandom);
    lb_rd_en = rd;
    stat_rd  = sr;
    @(posedge clk);
    model_edge();
    #1;
    chk(lb_wr_en === mwe, "R5", "write strobe", longint'(lb_wr_en), longint'(mwe));
    if (mwe) begin
      chk(lb_wr_data === mwd, "R3 R4 R7", "write word", longint'(lb_wr_data), longint'(mwd));
      if (mwd[19]) nflag++;
    end
    chk(int'(lb_occ) == mocc, "R6", "occupancy", longint'(lb_occ), longint'(mocc));
    chk(lb_full == (mocc == 256), "R7", "full", longint'(lb_full), longint'(mocc == 256));
    chk(drop_flags === mflags, "R1 R2 R8", "drop flags", longint'(drop_flags), longint'(mflags));
    if (mocc == 256) nfull++;
  endtask

  function automatic logic [7:0] rnd_hits(input int unsigned one_in);
    logic [7:0] v;
    for (int c = 0; c < 8; c++) v[c] = ($urandom % one_in) == 0;
    return v;
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_1234));
    hit_vld = '0; hit_meas = '0; lb_rd_en = 0; stat_rd = 0;
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk(lb_wr_en == 0,    "R9", "reset write", longint'(lb_wr_en), 0);
    chk(lb_occ == 0,      "R9", "reset occ",   longint'(lb_occ), 0);
    chk(lb_full == 0,     "R9", "reset full",  longint'(lb_full), 0);
    chk(drop_flags == 0,  "R9", "reset flags", longint'(drop_flags), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R5: single hit latency
    cycle(8'h40, 0, 0);
    chk(lb_wr_en == 0, "R5", "not yet written", longint'(lb_wr_en), 0);
    cycle(8'h00, 0, 0);
    chk(lb_wr_en == 1 && lb_wr_data[18:16] == 3'd6, "R5", "channel 6 out",
        longint'(lb_wr_data[18:16]), 6);

    // R4: two channels at once, after last grant 6 -> 2 first, then 5
    cycle(8'b0010_0100, 0, 0);
    cycle(8'h00, 0, 0);
    chk(lb_wr_data[18:16] == 3'd2, "R4", "first grant", longint'(lb_wr_data[18:16]), 2);
    cycle(8'h00, 0, 0);
    chk(lb_wr_data[18:16] == 3'd5, "R4", "second grant", longint'(lb_wr_data[18:16]), 5);

    // R1/R2: flood all channels
    repeat (8) cycle(8'hFF, 0, 0);
    chk(drop_flags == 8'hFF, "R1", "all channels dropped", longint'(drop_flags), 8'hFF);
    // R8 collision: discard and status read in the same cycle
    cycle(8'hFF, 0, 1);
    chk(drop_flags != 8'h00, "R8", "drop beats clear", longint'(drop_flags), longint'(mflags));
    repeat (40) cycle(8'h00, 1, 0);
    cycle(8'h00, 0, 1);
    chk(drop_flags == 8'h00, "R8", "cleared", longint'(drop_flags), 0);

    // random mixed traffic
    for (int i = 0; i < 3000; i++)
      cycle(rnd_hits(10), ($urandom % 2) == 0, ($urandom % 16) == 0);

    // fill to overflow, then drain
    for (int i = 0; i < 500; i++) cycle(rnd_hits(3), 0, ($urandom % 32) == 0);
    chk(nfull > 0, "R7", "buffer reached full", longint'(nfull), 1);
    for (int i = 0; i < 700; i++) cycle(rnd_hits(4), 1, 0);
    chk(nflag > 0, "R7", "lost marker seen", longint'(nflag), 1);

    // quiet drain, occupancy returns to zero, extra reads ignored
    for (int i = 0; i < 300; i++) cycle(8'h00, 1, 0);
    chk(lb_occ == 0, "R6", "drained", longint'(lb_occ), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule